// File: doc/BRIEF.md
# Mailbox Transfer Sequencer

This block drives a byte-wide parallel host port as its master on behalf of a local controller. It moves control messages to and from a peripheral processor that exposes two registers: a message register and a status register. Every byte crosses the port only after a status read shows that the peripheral can take it or has one to offer. Outbound bytes come from a FIFO-style source. Inbound bytes go to the controller with a one-cycle valid strobe.

The controller starts a transfer with a one-cycle command. A write sends a given number of bytes. A read collects a fixed-length reply of six bytes. A level input selects the boot handshake instead. In that handshake a write command always sends three bytes and then fetches a single reply byte. An active-low interrupt can start a six-byte read while the sequencer is idle, but only outside boot mode. A poll limit bounds how long the sequencer waits on the peripheral. When it is reached, the transfer ends with an error flag raised alongside the completion pulse.

Each bus access lasts one cycle. Chip-select is high together with exactly one of the read or write strobes. Read data is sampled on the same cycle as the read strobe.

Top module: `mbx_host_seq`

## Requirements
- R1: `bus_addr` 2'b00 selects the message register and 2'b01 selects the status register. Status polls use 2'b01. Byte writes and message reads use 2'b00.
- R2: A byte write happens only on the cycle directly after a status read that returned bit 2 (input busy) as 0, with `wr_valid` high on that same poll cycle. Otherwise the status read is repeated.
- R3: In run mode, a write command sends exactly `cmd_len` bytes in the order the source presents them. Each byte is taken with a one-cycle `wr_pop` on its write cycle. If `cmd_len` is 0, the command completes with no bus access.
- R4: In run mode, a read command fetches exactly six bytes. Each message read directly follows a status read that returned bit 1 (output ready) as 1.
- R5: `rd_valid` pulses on the cycle after each message read, with `rd_data` equal to the byte sampled during that read.
- R6: In boot mode (`boot_mode`=1 at the command), a write command sends exactly three bytes whatever `cmd_len` is. It then fetches exactly one reply byte before completing.
- R7: While idle in run mode, `irq_n` low starts a six-byte read. In boot mode `irq_n` causes no bus access.
- R8: After POLL_LIMIT consecutive status reads that do not let a transfer proceed, the transfer stops with `done` and `xfer_err` both high.
- R9: `done` is a single-cycle pulse on the cycle after the last access of a transfer. `xfer_err` is high only together with `done`.
- R10: `cmd_start` is ignored while a transfer is in progress.
- R11: On every cycle, at most one of `bus_rd` and `bus_wr` is high, and `bus_cs` is high exactly when one of them is. After reset all strobes, `done`, `xfer_err` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 1 | 1 selects the boot handshake, sampled at command start |
| cmd_start | input | 1 | One-cycle transfer request |
| cmd_write | input | 1 | 1 for a write transfer, 0 for a read |
| cmd_len | input | CNT_W | Number of bytes for a run-mode write |
| wr_data | input | DATA_W | Byte offered by the local source |
| wr_valid | input | 1 | Source has a byte available |
| wr_pop | output | 1 | Source byte consumed this cycle |
| rd_data | output | DATA_W | Received byte |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| done | output | 1 | Transfer completion pulse |
| xfer_err | output | 1 | Poll limit reached, valid with `done` |
| irq_n | input | 1 | Active-low outgoing-message interrupt |
| bus_cs | output | 1 | Port chip-select |
| bus_rd | output | 1 | Port read strobe |
| bus_wr | output | 1 | Port write strobe |
| bus_addr | output | 2 | Port register address |
| bus_wdata | output | DATA_W | Port write data |
| bus_rdata | input | DATA_W | Port read data |

## Verification
The assertions watch the per-cycle rules on every cycle. These are strobe exclusivity, the address used by writes, the status read that must come right before each write or message read, the timing and data of the read strobe, the width of the completion pulse, and the bound on consecutive polls. Only the bench scenarios can show the rules about counts and modes. These include how many bytes a run write, a run read or a boot exchange moves, that a zero length makes no access, that the interrupt starts a read in run mode but not in boot mode, and that a command arriving mid-transfer has no effect.

// File: rtl/mbx_pkg.sv
// Shared types for the mailbox transfer sequencer.
// Assumes a two-bit register address on the host port.
package mbx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_WR,
        ST_WRITE,
        ST_POLL_RD,
        ST_READ,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] ADDR_MSG  = 2'b00;
    localparam logic [1:0] ADDR_STAT = 2'b01;
endpackage

// File: rtl/mbx_poll_timer.sv
// Counts consecutive unsuccessful status polls and flags the poll that
// reaches the limit. Any cycle that is not a failed poll clears the count.
// Assumes POLL_LIMIT >= 2.
module mbx_poll_timer #(
    parameter int POLL_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic poll_miss,
    output logic poll_expire
);
    localparam int CW = $clog2(POLL_LIMIT);
    localparam logic [CW-1:0] LAST_C = CW'(POLL_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign poll_expire = poll_miss && (cnt_q == LAST_C);

    // Consecutive-miss counter, restarted by any successful or non-poll cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!poll_miss || poll_expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mbx_bus_port.sv
// Turns the sequencer state into one-cycle host port accesses and
// captures message bytes on the cycle their read strobe is high.
// Assumes bus_rdata is valid during the cycle of a read strobe.
module mbx_bus_port
    import mbx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BUSY_BIT = 2,
    parameter int RDY_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_cs,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [1:0]        bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              stat_busy,
    output logic              stat_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic msg_read;

    // Strobe and address decode for the current access.
    always_comb begin
        bus_cs   = 1'b0;
        bus_rd   = 1'b0;
        bus_wr   = 1'b0;
        bus_addr = ADDR_MSG;
        unique case (state)
            ST_POLL_WR, ST_POLL_RD: begin
                bus_cs   = 1'b1;
                bus_rd   = 1'b1;
                bus_addr = ADDR_STAT;
            end
            ST_WRITE: begin
                bus_cs = 1'b1;
                bus_wr = 1'b1;
            end
            ST_READ: begin
                bus_cs = 1'b1;
                bus_rd = 1'b1;
            end
            default: begin
                bus_cs = 1'b0;
            end
        endcase
    end

    assign msg_read   = (state == ST_READ);
    assign bus_wdata  = (state == ST_WRITE) ? wr_byte : '0;
    assign stat_busy  = bus_rdata[BUSY_BIT];
    assign stat_ready = bus_rdata[RDY_BIT];

    // Register each message byte and its valid strobe toward the local side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= msg_read;
            if (msg_read) begin
                rd_data <= bus_rdata;
            end
        end
    end
endmodule

// File: rtl/mbx_ctl_fsm.sv
// Transfer sequencer: selects write or read, tracks the remaining byte count,
// inserts a status poll before every byte and chains the boot reply.
// Assumes length parameters fit in CNT_W bits and are nonzero.
module mbx_ctl_fsm
    import mbx_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int RUN_RSP_LEN  = 6,
    parameter int BOOT_WR_LEN  = 3,
    parameter int BOOT_RSP_LEN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_mode,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [CNT_W-1:0] cmd_len,
    input  logic             irq_n,
    input  logic             wr_valid,
    input  logic             stat_busy,
    input  logic             stat_ready,
    input  logic             poll_expire,
    output seq_state_e       state,
    output logic             poll_miss,
    output logic             wr_pop,
    output logic             done,
    output logic             xfer_err
);
    localparam logic [CNT_W-1:0] RUN_RSP_C  = CNT_W'(RUN_RSP_LEN);
    localparam logic [CNT_W-1:0] BOOT_WR_C  = CNT_W'(BOOT_WR_LEN);
    localparam logic [CNT_W-1:0] BOOT_RSP_C = CNT_W'(BOOT_RSP_LEN);
    localparam logic [CNT_W-1:0] ONE_C      = CNT_W'(1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             boot_q, boot_d;
    logic             err_q, err_d;
    logic             wr_go;

    assign wr_go     = !stat_busy && wr_valid;
    assign poll_miss = ((state_q == ST_POLL_WR) && !wr_go) ||
                       ((state_q == ST_POLL_RD) && !stat_ready);

    // Next-state and byte-count logic.
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        boot_d  = boot_q;
        err_d   = err_q;
        unique case (state_q)
            ST_IDLE: begin
                err_d = 1'b0;
                if (cmd_start) begin
                    boot_d = boot_mode;
                    if (cmd_write) begin
                        left_d  = boot_mode ? BOOT_WR_C : cmd_len;
                        state_d = (!boot_mode && cmd_len == '0) ? ST_DONE : ST_POLL_WR;
                    end else begin
                        left_d  = boot_mode ? BOOT_RSP_C : RUN_RSP_C;
                        state_d = ST_POLL_RD;
                    end
                end else if (!boot_mode && !irq_n) begin
                    boot_d  = 1'b0;
                    left_d  = RUN_RSP_C;
                    state_d = ST_POLL_RD;
                end
            end
            ST_POLL_WR: begin
                if (wr_go) begin
                    state_d = ST_WRITE;
                end else if (poll_expire) begin
                    err_d   = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_WRITE: begin
                left_d = left_q - 1'b1;
                if (left_q == ONE_C) begin
                    if (boot_q) begin
                        left_d  = BOOT_RSP_C;
                        state_d = ST_POLL_RD;
                    end else begin
                        state_d = ST_DONE;
                    end
                end else begin
                    state_d = ST_POLL_WR;
                end
            end
            ST_POLL_RD: begin
                if (stat_ready) begin
                    state_d = ST_READ;
                end else if (poll_expire) begin
                    err_d   = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_READ: begin
                left_d  = left_q - 1'b1;
                state_d = (left_q == ONE_C) ? ST_DONE : ST_POLL_RD;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State, count, mode and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            boot_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            boot_q  <= boot_d;
            err_q   <= err_d;
        end
    end

    assign state    = state_q;
    assign wr_pop   = (state_q == ST_WRITE);
    assign done     = (state_q == ST_DONE);
    assign xfer_err = (state_q == ST_DONE) && err_q;
endmodule

// File: rtl/mbx_host_seq.sv
// Top of the mailbox transfer sequencer: host-port master that moves
// control bytes to and from a peripheral with a poll before every byte.
// Assumes one-cycle bus accesses and a FIFO-style byte source.
module mbx_host_seq
    import mbx_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int CNT_W        = 8,
    parameter int RUN_RSP_LEN  = 6,
    parameter int BOOT_WR_LEN  = 3,
    parameter int BOOT_RSP_LEN = 1,
    parameter int BUSY_BIT     = 2,
    parameter int RDY_BIT      = 1,
    parameter int POLL_LIMIT   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic [CNT_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              xfer_err,
    input  logic              irq_n,
    output logic              bus_cs,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [1:0]        bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    seq_state_e state;
    logic       stat_busy;
    logic       stat_ready;
    logic       poll_miss;
    logic       poll_expire;

    mbx_ctl_fsm #(
        .CNT_W       (CNT_W),
        .RUN_RSP_LEN (RUN_RSP_LEN),
        .BOOT_WR_LEN (BOOT_WR_LEN),
        .BOOT_RSP_LEN(BOOT_RSP_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_mode  (boot_mode),
        .cmd_start  (cmd_start),
        .cmd_write  (cmd_write),
        .cmd_len    (cmd_len),
        .irq_n      (irq_n),
        .wr_valid   (wr_valid),
        .stat_busy  (stat_busy),
        .stat_ready (stat_ready),
        .poll_expire(poll_expire),
        .state      (state),
        .poll_miss  (poll_miss),
        .wr_pop     (wr_pop),
        .done       (done),
        .xfer_err   (xfer_err)
    );

    mbx_poll_timer #(
        .POLL_LIMIT(POLL_LIMIT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .poll_miss  (poll_miss),
        .poll_expire(poll_expire)
    );

    mbx_bus_port #(
        .DATA_W  (DATA_W),
        .BUSY_BIT(BUSY_BIT),
        .RDY_BIT (RDY_BIT)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .wr_byte   (wr_data),
        .bus_rdata (bus_rdata),
        .bus_cs    (bus_cs),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat_busy (stat_busy),
        .stat_ready(stat_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/mbx_host_seq_chk.sv
// Protocol checker for the mailbox transfer sequencer, bound to the top.
// Assumes the bound instance uses the same parameter values.
module mbx_host_seq_chk
    import mbx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BUSY_BIT   = 2,
    parameter int RDY_BIT    = 1,
    parameter int POLL_LIMIT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              done,
    input logic              xfer_err,
    input logic              bus_cs,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);
    int poll_run;

    // Status reads since the last message access or completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_run <= 0;
        end else if (done || (bus_cs && bus_addr == ADDR_MSG)) begin
            poll_run <= 0;
        end else if (bus_rd && bus_addr == ADDR_STAT) begin
            poll_run <= poll_run + 1;
        end
    end

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr) && (bus_cs == (bus_rd || bus_wr)));

    p_write_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_addr == ADDR_MSG);

    p_write_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd && bus_addr == ADDR_STAT && !bus_rdata[BUSY_BIT] && wr_valid));

    p_read_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_MSG) |-> $past(bus_rd && bus_addr == ADDR_STAT && bus_rdata[RDY_BIT]));

    p_rdv_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_rd && bus_addr == ADDR_MSG));

    p_rdv_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data == $past(bus_rdata));

    p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_run <= POLL_LIMIT);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> done);
endmodule

bind mbx_host_seq mbx_host_seq_chk #(
    .DATA_W    (DATA_W),
    .BUSY_BIT  (BUSY_BIT),
    .RDY_BIT   (RDY_BIT),
    .POLL_LIMIT(POLL_LIMIT)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .done     (done),
    .xfer_err (xfer_err),
    .bus_cs   (bus_cs),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/test_mbx_host_seq.sv
// Bench: peripheral model, behavioural reference model compared every cycle,
// and scenario-level count checks.
module test_mbx_host_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_mode = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_len = 8'd0;
    logic [7:0] wr_data;
    logic       wr_valid = 1'b1;
    logic       wr_pop;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       done;
    logic       xfer_err;
    logic       irq_n = 1'b1;
    logic       bus_cs, bus_rd, bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;

    always #2 clk = ~clk;

    // Peripheral configuration (written by the stimulus only).
    int   cfg_busy_init = 0, cfg_busy_gap = 0, cfg_rdy_gap = 0;
    int   cfg_rsp_len = 6, cfg_rsp_base = 8'h40, cfg_wbase = 8'h11;
    logic per_clr = 1'b0;

    // Peripheral state (written by the peripheral process only).
    int busy_left = 0, rdy_left = 0, rsp_idx = 0, wr_idx = 0;
    logic per_rdy;

    assign per_rdy   = (rdy_left == 0) && (rsp_idx < cfg_rsp_len);
    assign bus_rdata = (bus_addr == 2'b01) ? {5'b0, busy_left != 0, per_rdy, 1'b0}
                                           : 8'(cfg_rsp_base + rsp_idx * 29);
    assign wr_data   = 8'(cfg_wbase + wr_idx * 37);

    always @(posedge clk) begin
        if (per_clr) begin
            busy_left <= cfg_busy_init;
            rdy_left  <= cfg_rdy_gap;
            rsp_idx   <= 0;
            wr_idx    <= 0;
        end else begin
            if (bus_cs && bus_rd && bus_addr == 2'b01) begin
                if (busy_left > 0) busy_left <= busy_left - 1;
                if (rdy_left > 0) rdy_left <= rdy_left - 1;
            end
            if (bus_cs && bus_rd && bus_addr == 2'b00) begin
                rsp_idx  <= rsp_idx + 1;
                rdy_left <= cfg_rdy_gap;
            end
            if (bus_cs && bus_wr) busy_left <= cfg_busy_gap;
            if (wr_pop) wr_idx <= wr_idx + 1;
        end
    end

    // Behavioural reference model: phase 0 idle, 1 poll before write, 2 write,
    // 3 poll before read, 4 read, 5 completion.
    int         m_phase = 0, m_left = 0, m_polls = 0;
    logic       m_boot = 1'b0, m_err = 1'b0, m_rdv = 1'b0;
    logic [7:0] m_rdd = 8'd0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= 0; m_left <= 0; m_polls <= 0;
            m_boot <= 1'b0; m_err <= 1'b0; m_rdv <= 1'b0; m_rdd <= 8'd0;
        end else begin
            m_rdv <= (m_phase == 4);
            if (m_phase == 4) m_rdd <= bus_rdata;
            case (m_phase)
                0: begin
                    m_err <= 1'b0; m_polls <= 0;
                    if (cmd_start) begin
                        m_boot <= boot_mode;
                        if (cmd_write) begin
                            m_left  <= boot_mode ? 3 : int'(cmd_len);
                            m_phase <= (!boot_mode && cmd_len == 0) ? 5 : 1;
                        end else begin
                            m_left  <= boot_mode ? 1 : 6;
                            m_phase <= 3;
                        end
                    end else if (!boot_mode && !irq_n) begin
                        m_boot <= 1'b0; m_left <= 6; m_phase <= 3;
                    end
                end
                1: begin
                    if (!bus_rdata[2] && wr_valid) begin m_polls <= 0; m_phase <= 2; end
                    else if (m_polls == 15) begin m_err <= 1'b1; m_phase <= 5; end
                    else m_polls <= m_polls + 1;
                end
                2: begin
                    m_left <= m_left - 1;
                    if (m_left == 1) begin
                        if (m_boot) begin m_left <= 1; m_phase <= 3; end
                        else m_phase <= 5;
                    end else m_phase <= 1;
                end
                3: begin
                    if (bus_rdata[1]) begin m_polls <= 0; m_phase <= 4; end
                    else if (m_polls == 15) begin m_err <= 1'b1; m_phase <= 5; end
                    else m_polls <= m_polls + 1;
                end
                4: begin
                    m_left  <= m_left - 1;
                    m_phase <= (m_left == 1) ? 5 : 3;
                end
                default: m_phase <= 0;
            endcase
        end
    end

    mbx_host_seq i_mbx_host_seq (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .cmd_start(cmd_start),
        .cmd_write(cmd_write), .cmd_len(cmd_len), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .xfer_err(xfer_err), .irq_n(irq_n), .bus_cs(bus_cs), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int         n_chk = 0, n_err = 0, cyc = 0;
    int         o_cs, o_stat, o_mrd, o_wr, o_pop, o_done, o_err, o_rdv, o_wbad;
    logic [7:0] obs_rd [16];

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        o_cs = 0; o_stat = 0; o_mrd = 0; o_wr = 0; o_pop = 0;
        o_done = 0; o_err = 0; o_rdv = 0; o_wbad = 0;
    endtask

    // One cycle: sample at the falling edge, compare with the model, record.
    task automatic tick();
        logic [8:0] act, exp;
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
        act = {bus_cs, bus_rd, bus_wr, bus_cs ? bus_addr : 2'b00, wr_pop, done, xfer_err, rd_valid};
        exp = {m_phase >= 1 && m_phase <= 4, m_phase == 1 || m_phase == 3 || m_phase == 4,
               m_phase == 2, (m_phase == 1 || m_phase == 3) ? 2'b01 : 2'b00,
               m_phase == 2, m_phase == 5, m_phase == 5 && m_err, m_rdv};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R11 cycle %0d: actual %b expected %b", cyc, act, exp);
        end
        if (rd_valid && m_rdv) chk("R5 model rd_data", int'(rd_data), int'(m_rdd));
        if (bus_cs) o_cs++;
        if (bus_rd && bus_addr == 2'b01) o_stat++;
        if (bus_rd && bus_addr == 2'b00) o_mrd++;
        if (bus_wr) begin
            if (bus_wdata != 8'(cfg_wbase + o_wr * 37)) o_wbad++;
            o_wr++;
        end
        if (wr_pop) o_pop++;
        if (done) o_done++;
        if (done && xfer_err) o_err++;
        if (rd_valid) begin
            if (o_rdv < 16) obs_rd[o_rdv] = rd_data;
            o_rdv++;
        end
    endtask

    task automatic setup();
        per_clr = 1'b1;
        tick();
        per_clr = 1'b0;
        clear_obs();
    endtask

    task automatic start(logic wr, int len);
        cmd_write = wr;
        cmd_len   = 8'(len);
        cmd_start = 1'b1;
        tick();
        cmd_start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400; i++) begin
            tick();
            if (done) break;
        end
        tick();
    endtask

    initial begin
        clear_obs();
        for (int i = 0; i < 3; i++) tick();
        chk("R11 reset bus_cs", int'(bus_cs), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R5 reset rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        tick();

        // R3 and R2: run write of 4 bytes, two busy polls after each write
        cfg_busy_gap = 2;
        setup();
        start(1'b1, 4);
        wait_done();
        chk("R3 write count", o_wr, 4);
        chk("R3 pop count", o_pop, 4);
        chk("R3 byte order", o_wbad, 0);
        chk("R2 status polls", o_stat, 10);
        chk("R1 no message reads on write", o_mrd, 0);
        chk("R9 single done", o_done, 1);
        chk("R9 no error", o_err, 0);

        // R3: zero length completes with no access
        setup();
        start(1'b1, 0);
        wait_done();
        chk("R3 zero length accesses", o_cs, 0);
        chk("R3 zero length done", o_done, 1);

        // R2: empty source holds the write back
        cfg_busy_gap = 0;
        setup();
        wr_valid = 1'b0;
        start(1'b1, 1);
        for (int i = 0; i < 5; i++) tick();
        chk("R2 no write while source empty", o_wr, 0);
        wr_valid = 1'b1;
        wait_done();
        chk("R2 write after source fills", o_wr, 1);

        // R4 and R5: run read of six bytes
        cfg_rdy_gap = 1; cfg_rsp_len = 6; cfg_rsp_base = 8'h40;
        setup();
        start(1'b0, 0);
        wait_done();
        chk("R4 message reads", o_mrd, 6);
        chk("R4 status polls", o_stat, 12);
        chk("R5 strobes", o_rdv, 6);
        for (int i = 0; i < 6; i++) chk("R5 byte value", int'(obs_rd[i]), (8'h40 + i * 29) & 8'hff);

        // R7: interrupt starts a run-mode read
        cfg_rdy_gap = 0; cfg_rsp_base = 8'h07;
        setup();
        irq_n = 1'b0;
        tick();
        irq_n = 1'b1;
        wait_done();
        chk("R7 irq read bytes", o_rdv, 6);
        chk("R7 irq first byte", int'(obs_rd[0]), 8'h07);

        // R7: interrupt ignored in boot mode
        setup();
        boot_mode = 1'b1;
        irq_n = 1'b0;
        for (int i = 0; i < 20; i++) tick();
        chk("R7 boot irq accesses", o_cs, 0);
        irq_n = 1'b1;

        // R6: boot handshake, three writes then one reply
        cfg_busy_gap = 1; cfg_rsp_len = 1; cfg_rsp_base = 8'hA5; cfg_rdy_gap = 2;
        setup();
        start(1'b1, 9);
        wait_done();
        chk("R6 boot writes", o_wr, 3);
        chk("R6 boot reply reads", o_mrd, 1);
        chk("R6 boot reply value", int'(obs_rd[0]), 8'hA5);
        chk("R6 boot done", o_done, 1);
        boot_mode = 1'b0;

        // R8: write stalls on a busy peripheral
        cfg_busy_init = 1000;
        setup();
        start(1'b1, 2);
        wait_done();
        chk("R8 write poll count", o_stat, 16);
        chk("R8 write none sent", o_wr, 0);
        chk("R8 write error", o_err, 1);
        cfg_busy_init = 0;

        // R8: read stalls with nothing to offer
        cfg_rsp_len = 0; cfg_rdy_gap = 0;
        setup();
        start(1'b0, 0);
        wait_done();
        chk("R8 read poll count", o_stat, 16);
        chk("R8 read error", o_err, 1);

        // R10: a second command mid-transfer is ignored
        cfg_busy_gap = 3; cfg_rsp_len = 6;
        setup();
        start(1'b1, 3);
        for (int i = 0; i < 3; i++) tick();
        start(1'b0, 0);
        wait_done();
        for (int i = 0; i < 4; i++) tick();
        chk("R10 writes", o_wr, 3);
        chk("R10 no reads", o_mrd, 0);
        chk("R10 one done", o_done, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule